// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

The block takes one 12-bit DAC sample at a time over a valid/ready stream port. It turns each sample into a 16-bit serial frame for a DAC that listens on SPI. A fixed 4-bit control code goes in front of the sample. The frame leaves as two bytes, most significant bit first, in SPI mode 0, and one active-low chip select spans the whole frame. When chip select rises, the DAC moves the new value to its analog output. The block marks that moment with a one-cycle `done` pulse.

The sample port follows these back-pressure rules. A sample is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the transmitter is idle. An upstream source may hold `in_valid` high with a sample waiting. The source keeps that sample on `in_data` until the handshake, and the next frame then starts as soon as `in_ready` returns. While `in_ready` is low, `in_valid` and `in_data` have no effect.

The serial clock comes from the system clock. Each SCLK phase lasts `HALF_DIV` system cycles, and `HALF_DIV` must be at least 2. The frame width (`CTRL_W + DATA_W`) must be a whole number of bytes. Bytes go out one at a time, and a byte is loaded only after the previous one reports that it is complete.

Top module: `dac_spi_tx`

## Requirements
- R1: A frame carries 16 bits, most significant bit first. Bits 15..12 are the control code 0011, bits 11..8 are sample bits 11..8, and bits 7..0 are sample bits 7..0.
- R2: SPI mode 0 is used. `sclk` idles low, and `mosi` never changes while `sclk` is high, so it is valid at every rising `sclk` edge.
- R3: `cs_n` falls before the first rising `sclk` edge of a frame and stays low across all of them. There are exactly 16 rising `sclk` edges per frame, and `sclk` is never high while `cs_n` is high.
- R4: Inside a frame, each `sclk` high phase and each low phase lasts exactly `HALF_DIV` system cycles. This also holds at the boundary between the two bytes, so the rise-to-rise period is always 2*`HALF_DIV`.
- R5: `cs_n` falls at least `HALF_DIV` cycles before the first rising `sclk` edge. It rises at least `HALF_DIV` cycles after the last falling edge. `done` is high for exactly one cycle, the first cycle in which `cs_n` reads high again.
- R6: `in_ready` is high when idle and drops on the cycle after a handshake. It stays low until `cs_n` has been high for one full SCLK period. Samples offered while `in_ready` is low start no frame and do not alter the frame in flight.
- R7: Between two frames, `cs_n` stays high for at least 2*`HALF_DIV` cycles, even when `in_valid` is held high throughout.
- R8: Samples 0 and 4095 produce the frames 0x3000 and 0x3FFF.
- R9: During and after reset, `cs_n` is 1, `sclk` is 0, `done` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Transmitter idle, sample will be taken |
| in_data | input | DATA_W | DAC sample value |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low chip select framing one transfer |
| done | output | 1 | One-cycle pulse when chip select returns high |

## Verification
The case where two functions meet is the end of one frame and the start of the next. A sample is already waiting with `in_valid` high while the previous frame is closing. The acceptance of that sample then falls in the very cycle that `in_ready` comes back, which is only a few cycles after `cs_n` rises and `done` pulses. The bench provokes this by holding `in_valid` high across two frames and changing `in_data` right after the first handshake. It judges the result by three things: both frames decode to the right words, exactly one `done` pulse occurs per frame, and the measured chip-select gap is at least 2*`HALF_DIV` cycles.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_HOLD
  } tx_state_t;
endpackage

// File: rtl/dac_spi_tick.sv
module dac_spi_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_spi_byte_shift.sv
module dac_spi_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sclk,
  output logic         mosi,
  output logic         fin
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  sr;
  logic [BW-1:0] bitn;
  logic          busy;

  assign mosi = busy & sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      bitn <= '0;
      busy <= 1'b0;
      sclk <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        sr   <= din;
        bitn <= '0;
        busy <= 1'b1;
        sclk <= 1'b0;
      end else if (busy && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bitn == BW'(W - 1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            sr   <= {sr[W-2:0], 1'b0};
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dac_spi_tx.sv
module dac_spi_tx
  import dac_spi_pkg::*;
#(
  parameter int                DATA_W    = 12,
  parameter int                CTRL_W    = 4,
  parameter logic [CTRL_W-1:0] CTRL_CODE = 4'b0011,
  parameter int                HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              done
);
  localparam int FRAME_W = CTRL_W + DATA_W;
  localparam int NBYTES  = FRAME_W / BYTE_W;
  localparam int IW      = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  tx_state_t          st;
  logic [FRAME_W-1:0] word;
  logic [IW-1:0]      bidx;
  logic [IW-1:0]      nidx;
  logic [FRAME_W-1:0] word_sh;
  logic [BYTE_W-1:0]  load_byte;
  logic               hflag;
  logic               tick;
  logic               fin;
  logic               load;
  logic               last_byte;

  assign in_ready  = (st == ST_IDLE);
  assign last_byte = (bidx == IW'(NBYTES - 1));
  assign nidx      = (st == ST_LEAD) ? '0 : bidx + 1'b1;
  assign word_sh   = word << (BYTE_W * int'(nidx));
  assign load_byte = word_sh[FRAME_W-1 -: BYTE_W];
  assign load      = ((st == ST_LEAD) && tick) ||
                     ((st == ST_SHIFT) && fin && !last_byte);

  dac_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st != ST_IDLE),
    .tick  (tick)
  );

  dac_spi_byte_shift #(.W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .load  (load),
    .din   (load_byte),
    .sclk  (sclk),
    .mosi  (mosi),
    .fin   (fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      word  <= '0;
      bidx  <= '0;
      hflag <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            word <= {CTRL_CODE, in_data};
            cs_n <= 1'b0;
            st   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            bidx <= '0;
            st   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fin) begin
            if (last_byte) st <= ST_TRAIL;
            else           bidx <= nidx;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            hflag <= 1'b0;
            st    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            if (hflag) st <= ST_IDLE;
            else       hflag <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_spi_tx_chk.sv
module dac_spi_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic done
);
  AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R3

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R2

  AST_NOT_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !in_ready); // R6

  AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !cs_n)); // R6

  AST_CS_FALL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(in_valid && in_ready)); // R3

  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n)); // R5

  AST_CS_RISE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
endmodule

bind dac_spi_tx dac_spi_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sclk     (sclk),
  .mosi     (mosi),
  .cs_n     (cs_n),
  .done     (done)
);

// File: tb/sim_dac_spi_tx.sv
`timescale 1ns/1ps
module sim_dac_spi_tx;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        in_ready, sclk, mosi, cs_n, done;

  always #4 clk = ~clk;

  dac_spi_tx #(.HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  // monitor state, sampled on falling clock edges
  int          cyc = 0;
  logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
  int          t_rise = -1, t_fall = -1, t_csf = -1, t_csr = -1;
  int          per_min = 1000, per_max = 0, hi_min = 1000, hi_max = 0;
  int          lo_min = 1000, lo_max = 0;
  int          lead_min = 1000, trail_min = 1000, gap_min = 1000;
  logic [15:0] sh = '0;
  int          nbits = 0;
  int          frames = 0;
  logic [15:0] words [0:31];
  int          bits_of [0:31];
  int          dones = 0, done_bad = 0;
  int          v_mode = 0, v_ready = 0, v_cs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc <= cyc + 1;
      if (sclk && cs_n) v_cs <= v_cs + 1;
      if (!cs_n && in_ready) v_ready <= v_ready + 1;
      if (sclk && p_sclk && (mosi !== p_mosi)) v_mode <= v_mode + 1;
      if (p_cs && !cs_n) begin
        nbits <= 0;
        t_csf <= cyc;
        if (t_csr >= 0 && (cyc - t_csr) < gap_min) gap_min <= cyc - t_csr;
      end
      if (sclk && !p_sclk) begin
        sh <= {sh[14:0], mosi};
        nbits <= nbits + 1;
        if (nbits == 0 && (cyc - t_csf) < lead_min) lead_min <= cyc - t_csf;
        if (nbits > 0) begin
          if (cyc - t_rise < per_min) per_min <= cyc - t_rise;
          if (cyc - t_rise > per_max) per_max <= cyc - t_rise;
          if (cyc - t_fall < lo_min)  lo_min  <= cyc - t_fall;
          if (cyc - t_fall > lo_max)  lo_max  <= cyc - t_fall;
        end
        t_rise <= cyc;
      end
      if (!sclk && p_sclk) begin
        if (cyc - t_rise < hi_min) hi_min <= cyc - t_rise;
        if (cyc - t_rise > hi_max) hi_max <= cyc - t_rise;
        t_fall <= cyc;
      end
      if (!p_cs && cs_n) begin
        words[frames[4:0]]   <= sh;
        bits_of[frames[4:0]] <= nbits;
        frames <= frames + 1;
        t_csr <= cyc;
        if (cyc - t_fall < trail_min) trail_min <= cyc - t_fall;
      end
      if (done) begin
        dones <= dones + 1;
        if (!(cs_n && !p_cs)) done_bad <= done_bad + 1;
      end
      p_sclk <= sclk;
      p_cs   <= cs_n;
      p_mosi <= mosi;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int guard = 0;
    while (frames < n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic offer(input logic [11:0] d);
    int guard = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [11:0] d, input string req);
    int base = frames;
    int db = dones;
    offer(d);
    wait_frames(base + 1);
    repeat (2) @(negedge clk);
    chk(words[base[4:0]] == {4'b0011, d}, req, int'(words[base[4:0]]), int'({4'b0011, d}));
    chk(bits_of[base[4:0]] == 16, "R3 bit count", bits_of[base[4:0]], 16);
    chk(dones == db + 1, "R5 done count", dones - db, 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R9 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R9 sclk", int'(sclk), 0);
    chk(done == 1'b0, "R9 done", int'(done), 0);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && in_ready == 1'b1, "R9 after release", int'({cs_n, in_ready}), 3);
  endtask

  task automatic t_basic;
    send_word(12'hA5C, "R1 frame A5C");
    send_word(12'h5A3, "R1 frame 5A3");
  endtask

  task automatic t_bounds;
    send_word(12'h000, "R8 zero");
    send_word(12'hFFF, "R8 full scale");
  endtask

  task automatic t_ignore;
    int base = frames;
    offer(12'h123);
    repeat (5) @(negedge clk);
    chk(in_ready == 1'b0, "R6 ready low in frame", int'(in_ready), 0);
    in_valid = 1'b1;
    in_data  = 12'hEEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    wait_frames(base + 1);
    repeat (12 * H) @(negedge clk);
    chk(frames == base + 1, "R6 no extra frame", frames - base, 1);
    chk(words[base[4:0]] == 16'h3123, "R6 word unchanged", int'(words[base[4:0]]), 16'h3123);
    chk(in_ready == 1'b1, "R6 ready back", int'(in_ready), 1);
  endtask

  task automatic t_back_to_back;
    int base = frames;
    int db = dones;
    int guard = 0;
    gap_min = 1000;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 12'h0F1;
    while (!in_ready && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    in_data = 12'hE0E;
    guard = 0;
    while (!in_ready && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    in_valid = 1'b0;
    wait_frames(base + 2);
    repeat (2) @(negedge clk);
    chk(words[base[4:0]] == 16'h30F1, "R7 first word", int'(words[base[4:0]]), 16'h30F1);
    chk(words[5'(base + 1)] == 16'h3E0E, "R7 second word", int'(words[5'(base + 1)]), 16'h3E0E);
    chk(gap_min >= 2 * H, "R7 cs gap", gap_min, 2 * H);
    chk(dones == db + 2, "R5 done per frame", dones - db, 2);
  endtask

  task automatic t_timing;
    chk(per_min == 2 * H && per_max == 2 * H, "R4 period", per_max, 2 * H);
    chk(per_min == 2 * H, "R4 period min", per_min, 2 * H);
    chk(hi_min == H && hi_max == H, "R4 high phase", hi_max, H);
    chk(lo_min == H && lo_max == H, "R4 low phase", lo_max, H);
    chk(lead_min >= H, "R5 lead", lead_min, H);
    chk(trail_min >= H, "R5 trail", trail_min, H);
    chk(done_bad == 0, "R5 done at cs rise", done_bad, 0);
    chk(v_mode == 0, "R2 mosi stable while sclk high", v_mode, 0);
    chk(v_cs == 0, "R3 sclk outside cs", v_cs, 0);
    chk(v_ready == 0, "R6 ready during frame", v_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_bounds();
    t_ignore();
    t_back_to_back();
    t_timing();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule